// File: doc/BRIEF.md
# Three-Phase 8-bit Processor Core

This block is a small 8-bit processor with four general registers and 16-bit instructions. Each instruction runs in three clock cycles. The first cycle reads the upper instruction byte from a byte-wide memory port. The second cycle reads the lower byte. The third cycle executes the instruction. One instruction pointer addresses memory for fetches. Execute cycles address memory only for loads and stores.

The core decodes these instruction classes:

- register and immediate moves
- loads and stores
- two-operand and one-operand ALU operations
- compare, which updates a four-bit flag register
- conditional and unconditional jumps
- reads from an 8-bit input port
- writes to a registered 8-bit output port

Debug outputs show the register contents, the instruction word, the current phase and the flags.

The memory read data is combinational: the addressed byte must be present in the same cycle. Every memory and port pin is a plain level signal. There is no handshake, so the core never stalls and never applies back-pressure.

Top module: `tri_phase_cpu8`

## Requirements
- R1: A phase counter steps 0 (upper fetch), 1 (lower fetch), 2 (execute), then back to 0. A synchronous active-high reset sets the phase to 0 and sets the pointer, instruction, registers, flags and output port to zero.
- R2: In phases 0 and 1, the memory address is the instruction pointer, and the pointer advances by one at the end of each of these phases. Phase 0 loads the read byte into instruction bits 15..8, and phase 1 loads it into bits 7..0.
- R3: The destination register index is in bits 9..8 and the source register index is in bits 1..0. The operand is bits 7..0 when bit 12 is 1, and the source register value when bit 12 is 0.
- R4: The ALU code is bits 14..10, with the destination as A and the operand as B. When the code's bits 4..3 are 01, its bits 1..0 select add (00), subtract (01), AND (10) or OR (11). Codes 10x00 give XOR.
- R5: Code 11000 gives NOT A, 11001 a logical right shift, 11010 a right rotate, 11011 an arithmetic right shift and 11100 a left rotate. Every other code gives 0.
- R6: The flags are computed from the 9-bit difference A−B and laid out {Z,O,C,S} from bit 3 down to bit 0. S is bit 7 of the difference and C is bit 8. Z is set when the low 8 bits are all zero. O is set on a sign change (non-negative minus negative giving negative, or negative minus non-negative giving non-negative). The flag register is written only in execute, for compare (bits 15..13=010, bits 11..10=01).
- R7: For bits 15..13=101, the pointer loads the operand's low bits at execute when the condition in bits 11..8 holds. The conditions are: 0000 always, 0001 Z=1, 1001 Z=0, 0010 Z=0 and C=0, 1011 Z=0 and C=1. In every other case the pointer holds during execute.
- R8: In execute, the memory address depends on bits 15..10. For 000001 it is the source register. For 000101 it is the immediate. For 000010 and 000110 it is the destination register. For every other value it is zero.
- R9: The memory write strobe is high only in execute, with bits 15..13=000 and bits 11..10=10. The write data is the operand.
- R10: The destination register is written only at execute. It is written for moves (class 000) whose bits 11..10 are not 10, and for ALU classes 001, 010 and 011 other than compare. It is also written for input. The data is the memory read data for a load (bits 11..10=01), the operand for other moves, the ALU result for ALU operations, and the input port for input.
- R11: Input is class 110 with bits 11..10=01. Output is class 110 with bits 11..10=00 and loads the operand into the output port at execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Combinational memory read data |
| io_in | input | 8 | External input port |
| io_out | output | 8 | Registered external output port |
| dbg_regs | output | 32 | Registers, r0 in bits 7..0 up to r3 in bits 31..24 |
| dbg_insn | output | 16 | Current instruction word |
| dbg_phase | output | 2 | Current phase code |
| dbg_flags | output | 4 | Flag register {Z,O,C,S} |

## Verification
Register, flag, pointer and output-port results appear one cycle after the execute phase begins, that is, after the third rising edge of the instruction. The memory address, write strobe and write data are valid during execute, after the second edge. The bench drives and samples on falling edges and counts them from the release of reset. It checks strobe and address values two falling edges into an instruction, and stored results three falling edges in. Whole programs are run a known number of instructions before their end state is checked.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int WORD_W = 8;
  localparam int INSN_W = 16;
  localparam int NREG   = 4;
  localparam int RIDX_W = $clog2(NREG);
  localparam int OP_W   = 5;

  typedef enum logic [1:0] {
    PH_HI = 2'b00,
    PH_LO = 2'b01,
    PH_EX = 2'b10
  } phase_e;

  typedef struct packed {
    logic z;
    logic o;
    logic c;
    logic s;
  } flags_t;

  localparam logic [2:0] CL_MOVE = 3'b000;
  localparam logic [2:0] CL_ALU2 = 3'b001;
  localparam logic [2:0] CL_ALUX = 3'b010;
  localparam logic [2:0] CL_ALU1 = 3'b011;
  localparam logic [2:0] CL_JUMP = 3'b101;
  localparam logic [2:0] CL_PORT = 3'b110;
endpackage

// File: rtl/cpu8_phase_seq.sv
module cpu8_phase_seq
  import cpu8_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= PH_HI;
    else begin
      case (phase)
        PH_HI:   phase <= PH_LO;
        PH_LO:   phase <= PH_EX;
        default: phase <= PH_HI;
      endcase
    end
  end

  // R1
  ex_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    phase == PH_EX |=> phase == PH_HI);
  // R1
  lo_follows_hi_chk: assert property (@(posedge clk) disable iff (rst)
    phase == PH_HI |=> phase == PH_LO);
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int N_ENT = 4,
  parameter int W     = 8,
  localparam int SW   = $clog2(N_ENT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [SW-1:0]      wsel,
  input  logic [W-1:0]       wdata,
  input  logic [SW-1:0]      rsel_a,
  input  logic [SW-1:0]      rsel_b,
  output logic [W-1:0]       rdata_a,
  output logic [W-1:0]       rdata_b,
  output logic [N_ENT*W-1:0] flat
);
  logic [W-1:0] ent [N_ENT];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_ENT; i++) begin
      if (rst) ent[i] <= '0;
      else if (we && wsel == SW'(i)) ent[i] <= wdata;
    end
  end

  assign rdata_a = ent[rsel_a];
  assign rdata_b = ent[rsel_b];

  for (genvar g = 0; g < N_ENT; g++) begin : g_flat
    assign flat[g*W +: W] = ent[g];
  end

  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(flat));
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y,
  output flags_t          f
);
  logic [W:0] diff;
  assign diff = {1'b0, a} - {1'b0, b};

  always_comb begin
    y = '0;
    if (op[4:3] == 2'b01) begin
      case (op[1:0])
        2'b00:   y = a + b;
        2'b01:   y = diff[W-1:0];
        2'b10:   y = a & b;
        default: y = a | b;
      endcase
    end else if (op[4:3] == 2'b10 && op[1:0] == 2'b00) begin
      y = a ^ b;
    end else begin
      case (op)
        5'b11000: y = ~a;
        5'b11001: y = {1'b0, a[W-1:1]};
        5'b11010: y = {a[0], a[W-1:1]};
        5'b11011: y = {a[W-1], a[W-1:1]};
        5'b11100: y = {a[W-2:0], a[W-1]};
        default:  y = '0;
      endcase
    end
  end

  assign f.s = diff[W-1];
  assign f.c = diff[W];
  assign f.z = ~|diff[W-1:0];
  assign f.o = (~a[W-1] & b[W-1] & diff[W-1]) | (a[W-1] & ~b[W-1] & ~diff[W-1]);
endmodule

// File: rtl/tri_phase_cpu8.sv
module tri_phase_cpu8
  import cpu8_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic                   mem_wr_en,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [WORD_W-1:0]      mem_wdata,
  input  logic [WORD_W-1:0]      mem_rdata,
  input  logic [WORD_W-1:0]      io_in,
  output logic [WORD_W-1:0]      io_out,
  output logic [NREG*WORD_W-1:0] dbg_regs,
  output logic [INSN_W-1:0]      dbg_insn,
  output logic [1:0]             dbg_phase,
  output logic [3:0]             dbg_flags
);
  phase_e            phase;
  logic [INSN_W-1:0] insn;
  logic [ADDR_W-1:0] ip;
  flags_t            flags, alu_f;
  logic [WORD_W-1:0] dst_val, src_val, operand, alu_y, wdata;
  logic [2:0]        cls;
  logic [1:0]        sub;
  logic              exec, is_move, is_alu, is_cmp, is_jump, is_in, is_out;
  logic              is_load, is_store, reg_we, cond_ok;

  cpu8_phase_seq u_seq (.clk(clk), .rst(rst), .phase(phase));

  always_ff @(posedge clk) begin
    if (rst) insn <= '0;
    else if (phase == PH_HI) insn[15:8] <= mem_rdata;
    else if (phase == PH_LO) insn[7:0] <= mem_rdata;
  end

  assign exec     = (phase == PH_EX);
  assign cls      = insn[15:13];
  assign sub      = insn[11:10];
  assign is_move  = (cls == CL_MOVE);
  assign is_alu   = (cls == CL_ALU2) || (cls == CL_ALUX) || (cls == CL_ALU1);
  assign is_cmp   = (cls == CL_ALUX) && (sub == 2'b01);
  assign is_jump  = (cls == CL_JUMP);
  assign is_in    = (cls == CL_PORT) && (sub == 2'b01);
  assign is_out   = (cls == CL_PORT) && (sub == 2'b00);
  assign is_load  = is_move && (sub == 2'b01);
  assign is_store = is_move && (sub == 2'b10);

  cpu8_regfile #(.N_ENT(NREG), .W(WORD_W)) u_rf (
    .clk(clk), .rst(rst), .we(reg_we), .wsel(insn[9:8]), .wdata(wdata),
    .rsel_a(insn[9:8]), .rsel_b(insn[1:0]),
    .rdata_a(dst_val), .rdata_b(src_val), .flat(dbg_regs));

  assign operand = insn[12] ? insn[7:0] : src_val;

  cpu8_alu #(.W(WORD_W)) u_alu (
    .op(insn[14:10]), .a(dst_val), .b(operand), .y(alu_y), .f(alu_f));

  assign reg_we = exec && ((is_move && !is_store) || (is_alu && !is_cmp) || is_in);

  always_comb begin
    if (is_load)      wdata = mem_rdata;
    else if (is_move) wdata = operand;
    else if (is_in)   wdata = io_in;
    else              wdata = alu_y;
  end

  assign mem_wdata = wdata;
  assign mem_wr_en = exec && is_store;

  always_comb begin
    if (!exec) mem_addr = ip;
    else begin
      case (insn[15:10])
        6'b000001:         mem_addr = src_val[ADDR_W-1:0];
        6'b000101:         mem_addr = insn[ADDR_W-1:0];
        6'b000010,
        6'b000110:         mem_addr = dst_val[ADDR_W-1:0];
        default:           mem_addr = '0;
      endcase
    end
  end

  always_comb begin
    case (insn[11:8])
      4'b0000: cond_ok = 1'b1;
      4'b0001: cond_ok = flags.z;
      4'b1001: cond_ok = !flags.z;
      4'b0010: cond_ok = !flags.z && !flags.c;
      4'b1011: cond_ok = !flags.z && flags.c;
      default: cond_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ip     <= '0;
      flags  <= '0;
      io_out <= '0;
    end else begin
      if (!exec) ip <= ip + ADDR_W'(1);
      else if (is_jump && cond_ok) ip <= operand[ADDR_W-1:0];
      if (exec && is_cmp) flags <= alu_f;
      if (exec && is_out) io_out <= operand;
    end
  end

  assign dbg_insn  = insn;
  assign dbg_phase = phase;
  assign dbg_flags = flags;

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
    phase != PH_EX |=> ip == $past(ip) + ADDR_W'(1));
  // R2
  upper_byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    phase != PH_HI |=> $stable(insn[15:8]));
  // R7
  no_jump_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EX && insn[15:13] != CL_JUMP) |=> ip == $past(ip));
  // R6
  flags_fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    phase != PH_EX |=> $stable(dbg_flags));
  // R9
  store_in_exec_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> phase == PH_EX);
  // R11
  port_fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    phase != PH_EX |=> $stable(io_out));
endmodule

// File: tb/tri_phase_cpu8_tb.sv
module tri_phase_cpu8_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_wr_en;
  logic [4:0]  mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, io_out;
  logic [7:0]  io_in = 8'h6D;
  logic [31:0] dbg_regs;
  logic [15:0] dbg_insn;
  logic [1:0]  dbg_phase;
  logic [3:0]  dbg_flags;
  logic [7:0]  mem [0:31];
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tri_phase_cpu8 #(.ADDR_W(5)) u_dut (
    .clk(clk), .rst(rst), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_in(io_in),
    .io_out(io_out), .dbg_regs(dbg_regs), .dbg_insn(dbg_insn),
    .dbg_phase(dbg_phase), .dbg_flags(dbg_flags));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr_en) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [7:0] hi, input logic [7:0] lo);
    mem[a] = hi;
    mem[a+1] = lo;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (3 * n) @(negedge clk);
  endtask

  task automatic t_reset_and_phases();
    clear_mem();
    put(0, 8'h10, 8'h05);
    put(2, 8'hB0, 8'h02);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "reset phase", dbg_phase, 0);
    chk("R1", "reset regs", dbg_regs, 0);
    chk("R1", "reset flags/port/insn", {dbg_flags, io_out, dbg_insn}, 0);
    chk("R1", "reset address", mem_addr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", "phase1 addr/upper byte", {dbg_phase, 3'b0, mem_addr, dbg_insn[15:8]},
        {2'd1, 3'b0, 5'd1, 8'h10});
    @(negedge clk);
    chk("R2", "phase2 insn", {dbg_phase, dbg_insn}, {2'd2, 16'h1005});
    @(negedge clk);
    chk("R1", "wrap and pointer", {dbg_phase, 3'b0, mem_addr}, {2'd0, 3'b0, 5'd2});
    chk("R3", "immediate move", dbg_regs[7:0], 8'h05);
  endtask

  task automatic t_alu_one_operand();
    clear_mem();
    put(0, 8'h10, 8'h81); put(2, 8'h01, 8'h00); put(4, 8'h61, 8'h00);
    put(6, 8'h02, 8'h00); put(8, 8'h66, 8'h00); put(10, 8'h03, 8'h00);
    put(12, 8'h6F, 8'h00); put(14, 8'h68, 8'h00); put(16, 8'hB0, 8'h10);
    do_reset();
    run(9);
    chk("R5", "not/shr/sar/ror", dbg_regs, 32'hC0407EC0);
  endtask

  task automatic t_alu_two_operand();
    clear_mem();
    put(0, 8'h10, 8'h81); put(2, 8'h70, 8'h00); put(4, 8'h11, 8'hF0);
    put(6, 8'h31, 8'h20); put(8, 8'h12, 8'h0F); put(10, 8'h36, 8'h10);
    put(12, 8'h13, 8'hCC); put(14, 8'h2F, 8'h00); put(16, 8'h53, 8'hFF);
    put(18, 8'h3A, 8'h3C); put(20, 8'h75, 8'h00); put(22, 8'hB0, 8'h16);
    do_reset();
    run(6);
    chk("R4", "rol/add/sub", dbg_regs[23:0], 24'hFF1003);
    run(7);
    chk("R4", "or/xor/and", {dbg_regs[31:16], dbg_regs[7:0]}, 24'h303C03);
    chk("R5", "unused code gives zero", dbg_regs[15:8], 8'h00);
  endtask

  task automatic t_compare();
    clear_mem();
    put(0, 8'h10, 8'h05); put(2, 8'h54, 8'h07); put(4, 8'h54, 8'h05);
    put(6, 8'h11, 8'h80); put(8, 8'h55, 8'h01); put(10, 8'h31, 8'h01);
    put(12, 8'hB0, 8'h0C);
    do_reset();
    run(2);
    chk("R6", "5-7 flags", dbg_flags, 4'h3);
    chk("R6", "compare leaves register", dbg_regs[7:0], 8'h05);
    run(1);
    chk("R6", "5-5 flags", dbg_flags, 4'h8);
    run(2);
    chk("R6", "80-01 overflow", dbg_flags, 4'h4);
    run(1);
    chk("R6", "add leaves flags", {dbg_flags, dbg_regs[15:8]}, {4'h4, 8'h81});
  endtask

  task automatic t_jumps();
    clear_mem();
    put(0, 8'h10, 8'h05); put(2, 8'h54, 8'h05); put(4, 8'hB1, 8'h08);
    put(6, 8'h11, 8'h11); put(8, 8'h11, 8'hEE); put(10, 8'hB9, 8'h10);
    put(12, 8'h12, 8'h22); put(14, 8'h54, 8'h06); put(16, 8'hBB, 8'h16);
    put(18, 8'h12, 8'h99); put(20, 8'h12, 8'h99); put(22, 8'hB2, 8'h1A);
    put(24, 8'h13, 8'h33); put(26, 8'h10, 8'h1E); put(28, 8'hA0, 8'h00);
    put(30, 8'hB0, 8'h1E);
    do_reset();
    run(15);
    chk("R7", "taken/untaken path", dbg_regs, 32'h3322EE1E);
    chk("R7", "register jump target", mem_addr, 5'h1E);
  endtask

  task automatic t_memory_and_ports();
    clear_mem();
    mem[28] = 8'hA7; mem[29] = 8'h3B;
    put(0, 8'h10, 8'h1C); put(2, 8'h05, 8'h00); put(4, 8'h16, 8'h1D);
    put(6, 8'h13, 8'h1F); put(8, 8'h0B, 8'h01); put(10, 8'h18, 8'h55);
    put(12, 8'hC4, 8'h00); put(14, 8'hD0, 8'h9C); put(16, 8'hC0, 8'h02);
    put(18, 8'hB0, 8'h12);
    do_reset();
    run(1);
    repeat (2) @(negedge clk);
    chk("R8", "load via register addr", {mem_wr_en, mem_addr}, {1'b0, 5'h1C});
    @(negedge clk);
    chk("R10", "load data", dbg_regs[15:8], 8'hA7);
    repeat (2) @(negedge clk);
    chk("R8", "load via immediate addr", mem_addr, 5'h1D);
    @(negedge clk);
    chk("R10", "load imm data", dbg_regs[23:16], 8'h3B);
    repeat (2) @(negedge clk);
    chk("R8", "plain move addr zero", mem_addr, 5'h00);
    @(negedge clk);
    @(negedge clk);
    chk("R9", "no strobe in fetch", mem_wr_en, 1'b0);
    @(negedge clk);
    chk("R9", "store strobe/addr/data", {mem_wr_en, mem_addr, mem_wdata},
        {1'b1, 5'h1F, 8'hA7});
    @(negedge clk);
    chk("R9", "stored byte", mem[31], 8'hA7);
    run(1);
    chk("R9", "store imm byte", mem[28], 8'h55);
    chk("R10", "store leaves registers", dbg_regs, 32'h1F3BA71C);
    run(1);
    chk("R11", "input to register", dbg_regs[7:0], 8'h6D);
    run(1);
    chk("R11", "output immediate", io_out, 8'h9C);
    run(1);
    chk("R11", "output register", io_out, 8'h3B);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset_and_phases();
    t_alu_one_operand();
    t_alu_two_operand();
    t_compare();
    t_jumps();
    t_memory_and_ports();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule